// File: doc/BRIEF.md
# Flag-Updating Barrel Shift Unit

This block shifts an 8-, 16- or 32-bit operand left or right by up to 31 places in a single pass. It supports four kinds of shift: two left shifts that behave identically and feed zeros in from the bottom, a logical right shift that fills the top with zeros, and an arithmetic right shift that copies the sign bit down. Alongside the result it returns a carry flag and an overflow flag. A separate update strobe for each flag tells the consumer whether that flag should be written back to its flag register.

The caller supplies the current carry and overflow values with each request. Whenever a shift leaves a flag untouched, the incoming value passes through unchanged and the matching update strobe stays low. Requests enter through a valid/ready handshake, and results leave through another. The result register holds a single entry. A new request is accepted when the register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds steady and `in_ready` stays low.

Top module: `shift_flag_unit`

## Requirements
- R1: A request accepted at a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high right after the next rising edge.
- R2: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data`, `out_cf`, `out_of`, `out_cf_upd` and `out_of_upd` keep their values.
- R3: Only bits [4:0] of `in_count` are used. Counts of 32 and 0xE0 act as 0, and 0x21 acts as 1.
- R4: Kind encoding: 0 = logical left, 1 = arithmetic left, 2 = logical right, 3 = arithmetic right. Both left kinds shift in zeros at bit 0 and give identical results and flags.
- R5: A logical right shift fills the vacated high positions of the selected width with zeros.
- R6: An arithmetic right shift fills the vacated high positions with the operand's sign bit (the top bit of the selected width).
- R7: Size encoding: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. Operand bits above the width are ignored, and result bits above the width are zero.
- R8: For a nonzero count, `out_cf` is the last bit shifted out. For left shifts this is the bit leaving the top of the width. For right shifts it is the bit leaving bit 0. If the count exceeds the width, the value is 0, except for arithmetic right, where it is the sign. `out_cf_upd` is 1.
- R9: For a count of 1, `out_of` is 1 exactly when the top bit of the result differs from the top bit of the operand, and `out_of_upd` is 1. This makes an arithmetic right shift by 1 always give 0.
- R10: For a count of 0, the result equals the width-masked operand, `out_cf` equals `in_cf`, `out_of` equals `in_of`, and both update strobes are 0.
- R11: For counts of 2 to 31, `out_of` equals `in_of` and `out_of_upd` is 0.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can take a request |
| in_data | input | 32 | Operand |
| in_kind | input | 2 | Shift kind (R4) |
| in_size | input | 2 | Operand width select (R7) |
| in_count | input | 8 | Shift count, low 5 bits used |
| in_cf | input | 1 | Current carry flag |
| in_of | input | 1 | Current overflow flag |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | 32 | Shifted result, zero above width |
| out_cf | output | 1 | Carry flag after the shift |
| out_of | output | 1 | Overflow flag after the shift |
| out_cf_upd | output | 1 | Carry flag should be written |
| out_of_upd | output | 1 | Overflow flag should be written |

## Verification
The clocked properties check the following on every cycle:
- the one-cycle latency from acceptance to output;
- holding of the output under back-pressure;
- pass-through of the flags for masked zero counts;
- the behaviour of overflow for counts above one;
- a cleared overflow for single-bit arithmetic right shifts.

The datapath results are shown only by the bench's sweeps. These cover every kind, size and count from 0 to 40, plus counts with high bits set, over sign- and edge-heavy operands. The sweeps expose the values of the fill bits, the carry when the count runs past the width, the sign-change overflow, and the masking of operand bits above the width.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_ASL = 2'd1,
    SK_LSR = 2'd2,
    SK_ASR = 2'd3
  } shift_kind_e;

  function automatic logic kind_is_left(input logic [1:0] k);
    return (k == SK_LSL) || (k == SK_ASL);
  endfunction
endpackage

// File: rtl/shf_datapath.sv
module shf_datapath #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W),
  parameter int IDX_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [1:0]        kind,
  input  logic [1:0]        size,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] result,
  output logic              carry,
  output logic              old_msb,
  output logic              new_msb
);
  import shf_pkg::*;

  localparam int W2 = 2 * DATA_W;

  logic [IDX_W-1:0]  width;
  logic [IDX_W-1:0]  top_idx;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] opm;
  logic [W2-1:0]     left_w;
  logic [W2-1:0]     ext;
  logic [W2:0]       right_w;

  always_comb begin
    case (size)
      2'd0:    width = IDX_W'(8);
      2'd1:    width = IDX_W'(16);
      default: width = IDX_W'(DATA_W);
    endcase
    top_idx = width - IDX_W'(1);
    mask    = DATA_W'((W2'(1) << width) - W2'(1));
    opm     = opnd & mask;
    old_msb = opm[top_idx];

    left_w  = W2'(opm) << cnt;

    if (kind == SK_ASR && old_msb) ext = ~W2'(mask) | W2'(opm);
    else                           ext = W2'(opm);
    right_w = {ext, 1'b0} >> cnt;

    if (kind_is_left(kind)) begin
      result = left_w[DATA_W-1:0] & mask;
      carry  = left_w[width];
    end else begin
      result = right_w[DATA_W:1] & mask;
      carry  = right_w[0];
    end
    new_msb = result[top_idx];
  end
endmodule

// File: rtl/shf_flagsel.sv
module shf_flagsel #(
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             carry,
  input  logic             old_msb,
  input  logic             new_msb,
  input  logic             cf_in,
  input  logic             of_in,
  output logic             cf_out,
  output logic             of_out,
  output logic             cf_upd,
  output logic             of_upd
);
  logic is_zero, is_one;

  always_comb begin
    is_zero = (cnt == '0);
    is_one  = (cnt == CNT_W'(1));
    cf_upd  = !is_zero;
    of_upd  = is_one;
    cf_out  = is_zero ? cf_in : carry;
    of_out  = is_one ? (old_msb ^ new_msb) : of_in;
  end

  always_comb begin
    assert_of_needs_cf_R9: assert (!of_upd || cf_upd);
  end
endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit #(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [1:0]          in_kind,
  input  logic [1:0]          in_size,
  input  logic [CNT_IN_W-1:0] in_count,
  input  logic                in_cf,
  input  logic                in_of,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_cf,
  output logic                out_of,
  output logic                out_cf_upd,
  output logic                out_of_upd
);
  import shf_pkg::*;

  localparam int CNT_W = $clog2(DATA_W);

  logic [CNT_W-1:0]  cnt_m;
  logic [DATA_W-1:0] res_c;
  logic              carry_c, old_msb_c, new_msb_c;
  logic              cf_c, of_c, cfu_c, ofu_c;
  logic              accept;

  assign cnt_m    = in_count[CNT_W-1:0];
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  shf_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .opnd    (in_data),
    .kind    (in_kind),
    .size    (in_size),
    .cnt     (cnt_m),
    .result  (res_c),
    .carry   (carry_c),
    .old_msb (old_msb_c),
    .new_msb (new_msb_c)
  );

  shf_flagsel #(.CNT_W(CNT_W)) u_fl (
    .cnt     (cnt_m),
    .carry   (carry_c),
    .old_msb (old_msb_c),
    .new_msb (new_msb_c),
    .cf_in   (in_cf),
    .of_in   (in_of),
    .cf_out  (cf_c),
    .of_out  (of_c),
    .cf_upd  (cfu_c),
    .of_upd  (ofu_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_cf     <= 1'b0;
      out_of     <= 1'b0;
      out_cf_upd <= 1'b0;
      out_of_upd <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        out_data   <= res_c;
        out_cf     <= cf_c;
        out_of     <= of_c;
        out_cf_upd <= cfu_c;
        out_of_upd <= ofu_c;
      end
    end
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_cf)
                                   && $stable(out_of) && $stable(out_cf_upd)
                                   && $stable(out_of_upd)));

  assert_zero_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_count[CNT_W-1:0] == '0) |=>
      (!out_cf_upd && !out_of_upd && out_cf == $past(in_cf) && out_of == $past(in_of)));

  assert_multi_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_count[CNT_W-1:0] > CNT_W'(1)) |=>
      (out_cf_upd && !out_of_upd && out_of == $past(in_of)));

  assert_asr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_kind == SK_ASR && in_count[CNT_W-1:0] == CNT_W'(1)) |=>
      (out_of_upd && !out_of));
endmodule

// File: tb/sim_shift_flag_unit.sv
module sim_shift_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [1:0]  in_kind = '0;
  logic [1:0]  in_size = '0;
  logic [7:0]  in_count = '0;
  logic        in_cf = 1'b0;
  logic        in_of = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_cf, out_of, out_cf_upd, out_of_upd;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  shift_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_kind(in_kind), .in_size(in_size), .in_count(in_count),
    .in_cf(in_cf), .in_of(in_of), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_cf(out_cf), .out_of(out_of),
    .out_cf_upd(out_cf_upd), .out_of_upd(out_of_upd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (kind=%0d size=%0d cnt=%h op=%h)",
               req, act, exp, in_kind, in_size, in_count, in_data);
    end
  endtask

  // iterative single-step reference, one bit per step
  task automatic model(input logic [1:0] k, input logic [1:0] s, input logic [31:0] op,
                       input logic [7:0] c8, input logic cfi, input logic ofi,
                       output logic [31:0] r, output logic cf, output logic of,
                       output logic cfu, output logic ofu);
    int n;
    int c;
    logic [31:0] m;
    logic [31:0] v;
    logic sgn;
    n = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    c = int'(c8 & 8'h1F);
    v = op & m;
    cf = cfi; of = ofi; cfu = 1'b0; ofu = 1'b0;
    for (int i = 0; i < c; i++) begin
      if (k < 2'd2) begin
        cf = v[n-1];
        v = (v << 1) & m;
      end else begin
        cf = v[0];
        sgn = (k == 2'd3) ? v[n-1] : 1'b0;
        v = v >> 1;
        v[n-1] = sgn;
      end
    end
    if (c >= 1) cfu = 1'b1;
    if (c == 1) begin
      of = v[n-1] ^ op[n-1];
      ofu = 1'b1;
    end
    r = v;
  endtask

  function automatic string req_for(input logic [1:0] k, input logic [7:0] c8, input logic [1:0] s);
    if ((c8 & 8'h1F) == 0) return "R10";
    if (c8 > 8'h1F) return "R3";
    if (s == 2'd0 || s == 2'd1) return "R7";
    if (k == 2'd2) return "R5";
    if (k == 2'd3) return "R6";
    return "R4";
  endfunction

  task automatic run_one(input logic [1:0] k, input logic [1:0] s, input logic [31:0] op,
                         input logic [7:0] c8, input logic cfi, input logic ofi);
    logic [31:0] er;
    logic ecf, eof, ecu, eou;
    model(k, s, op, c8, cfi, ofi, er, ecf, eof, ecu, eou);
    in_kind = k; in_size = s; in_data = op; in_count = c8; in_cf = cfi; in_of = ofi;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 valid", {31'd0, out_valid}, 32'd1);
    check(req_for(k, c8, s), out_data, er);
    check(((c8 & 8'h1F) == 0) ? "R10 cf" : "R8 cf", {31'd0, out_cf}, {31'd0, ecf});
    check(((c8 & 8'h1F) == 1) ? "R9 of" : "R11 of", {31'd0, out_of}, {31'd0, eof});
    check("R8 cf_upd", {31'd0, out_cf_upd}, {31'd0, ecu});
    check("R11 of_upd", {31'd0, out_of_upd}, {31'd0, eou});
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] ops [11];
    logic [7:0]  extra [4];
    ops[0] = 32'h0000_0000; ops[1] = 32'hFFFF_FFFF; ops[2] = 32'h8000_0000;
    ops[3] = 32'h0000_0080; ops[4] = 32'h0000_8000; ops[5] = 32'h1234_5678;
    ops[6] = 32'hA5C3_0F81; ops[7] = 32'h4000_4041; ops[8] = 32'h0000_007F;
    ops[9] = 32'h0000_00C0; ops[10] = 32'h55AA_55AA;
    extra[0] = 8'hE0; extra[1] = 8'hE1; extra[2] = 8'h3F; extra[3] = 8'hFF;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R12 out_valid", {31'd0, out_valid}, 32'd0);
    check("R12 in_ready", {31'd0, in_ready}, 32'd1);

    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 11; o++) begin
          for (int c = 0; c <= 40; c++)
            run_one(2'(k), 2'(s), ops[o], 8'(c), 1'(o), 1'(o + 1));
          for (int e = 0; e < 4; e++)
            run_one(2'(k), 2'(s), ops[o], extra[e], 1'(o + 1), 1'(o));
        end

    // R2: back-pressure holds the output and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    run_one(2'd3, 2'd0, 32'h0000_0081, 8'd1, 1'b0, 1'b1); // out 0xC0, cf 1, of 0
    in_kind = 2'd0; in_size = 2'd2; in_data = 32'h0000_0003; in_count = 8'd4;
    in_valid = 1'b1;
    check("R2 in_ready low", {31'd0, in_ready}, 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2 held valid", {31'd0, out_valid}, 32'd1);
    check("R2 held data", out_data, 32'h0000_00C0);
    check("R2 held cf", {31'd0, out_cf}, 32'd1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 next data", out_data, 32'h0000_0030);
    check("R2 next valid", {31'd0, out_valid}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    check("R1 idle drop", {31'd0, out_valid}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule